// File: doc/BRIEF.md
# Banked Memory Card Controller

This block stands in for a 12-bit-word memory card on a shared minicomputer memory bus. The card's storage is a synchronous array in place of magnetic core. A 3-bit field number extends the 12-bit word address. The eight fields it selects each hold one bank of words, and a bank of static switches can hand any field over to another card. Once a clock has registered the bus controls, the card decides each cycle whether it is selected. When the processor is reading, the card drives the addressed word onto the memory-data bus. When the processor is depositing, the card commits the bus word into the array.

The card reads without destroying data, so a read never writes anything back. The array changes only on an explicit deposit: the direction line shows processor-to-memory, the write line is asserted and the source strobe is asserted, all at once. Three things remove the card from the bus, and they all feed one select term: a disable switch set for the addressed field, an asserted ROM-overlay select, or a missing power-good indication. Every bus input passes through one register before any decision uses it. The read word is then formed combinationally from the registered address.

The array depth is a parameter. `IMPL_BITS` sets how many low word-address bits are implemented in each field. At 12 it gives the full 4K words per field. The default is 8, which keeps the elaborated array small.

Top module: `bank_memory_card`

## Requirements
- R1: The storage location is chosen by the field number together with the low `IMPL_BITS` bits of the word address. The same word address in two different fields reaches two independent words.
- R2: The switch at bit i of `fieldDisable` (bit 0 is field 0, bit 7 is field 7) removes field i from this card. While it is set, an access to that field neither drives the bus nor changes the stored word.
- R3: While `romSelN` is low, the card neither drives the bus nor writes.
- R4: A word is stored only when all four hold in the same registered cycle: `mdDirN` is high, `writeN` is low, `sourceN` is low and the card is selected. A strobe without the write line, or with the direction line low, stores nothing.
- R5: Each rise of the combined write condition commits exactly one write. It uses the address and data registered in that cycle, so changing the address or data later in the same long strobe has no effect.
- R6: While `mdDirN` is low and the card is selected, `dataOe` is high and `dataOut` carries the stored 12-bit word. Both follow the inputs one clock later. A read never modifies any stored word.
- R7: While `powerOk` is low, the card neither drives nor writes, and it stays inhibited for as long as `powerOk` stays low.
- R8: During and after reset, `dataOe` stays low until a selected read is registered. Whenever `dataOe` is low, `dataOut` is zero.
- R9: Word-address bits at or above `IMPL_BITS` are ignored, so two addresses that differ only in those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous reset, active high |
| fieldIn | input | FIELD_BITS | Extended field number |
| addrIn | input | ADDR_BITS | Word address within the field |
| mdIn | input | DATA_BITS | Memory-data bus value seen by the card |
| mdDirN | input | 1 | Direction, low means memory-to-processor |
| writeN | input | 1 | Write request, active low |
| sourceN | input | 1 | Source strobe, active low |
| romSelN | input | 1 | ROM overlay select, active low |
| powerOk | input | 1 | Power good, high when supply is valid |
| fieldDisable | input | 2**FIELD_BITS | Per-field disable switches |
| dataOe | output | 1 | Enable for the card's memory-data bus drivers |
| dataOut | output | DATA_BITS | Word driven onto the memory-data bus |

## Verification
The bench builds the card with `IMPL_BITS` set to 4. That gives 16 words per field and 128 in total. A behavioural model can then track the whole array, and aliasing appears as soon as address bit 4 is set. The field count stays at eight, so every disable switch and the decode of every field can be reached. The model's register stage and edge-detected deposit are compared with the outputs on every clock. Directed phases cover long strobes, strobes that should be ignored, ROM overlay and loss of power.

// File: rtl/bank_memory_card_pkg.sv
package bank_memory_card_pkg;
  typedef struct packed {
    logic wrStrobe;
    logic rdDrive;
  } ctlStrobe_t;
endpackage

// File: rtl/bank_memory_card_ctrl.sv
module bank_memory_card_ctrl
  import bank_memory_card_pkg::*;
#(
  parameter int FIELD_BITS = 3,
  parameter int ADDR_BITS  = 12,
  parameter int IMPL_BITS  = 8,
  parameter int DATA_BITS  = 12,
  localparam int FIELDS    = 1 << FIELD_BITS,
  localparam int IDX_BITS  = FIELD_BITS + IMPL_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [FIELD_BITS-1:0] fieldIn,
  input  logic [ADDR_BITS-1:0] addrIn,
  input  logic [DATA_BITS-1:0] mdIn,
  input  logic                 mdDirN,
  input  logic                 writeN,
  input  logic                 sourceN,
  input  logic                 romSelN,
  input  logic                 powerOk,
  input  logic [FIELDS-1:0]    fieldDisable,
  output ctlStrobe_t           strobe,
  output logic [IDX_BITS-1:0]  idxReg,
  output logic [DATA_BITS-1:0] dataReg
);
  logic [FIELD_BITS-1:0] fieldReg;
  logic [FIELDS-1:0]     disableReg;
  logic                  dirNReg, writeNReg, sourceNReg, romSelNReg, powerOkReg;
  logic [FIELDS-1:0]     fieldHit;
  logic                  cardSel, depositNow, depositPrev;

  // Bus sampling stage
  always_ff @(posedge clk) begin
    if (rst) begin
      fieldReg   <= '0;
      idxReg     <= '0;
      dataReg    <= '0;
      disableReg <= '0;
      dirNReg    <= 1'b0;
      writeNReg  <= 1'b1;
      sourceNReg <= 1'b1;
      romSelNReg <= 1'b0;
      powerOkReg <= 1'b0;
    end else begin
      fieldReg   <= fieldIn;
      idxReg     <= {fieldIn, IMPL_BITS'(addrIn)};
      dataReg    <= mdIn;
      disableReg <= fieldDisable;
      dirNReg    <= mdDirN;
      writeNReg  <= writeN;
      sourceNReg <= sourceN;
      romSelNReg <= romSelN;
      powerOkReg <= powerOk;
    end
  end

  // Field decoder, enabled only while ROM overlay is inactive
  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    assign fieldHit[f] = romSelNReg && (fieldReg == FIELD_BITS'(f)) && !disableReg[f];
  end

  assign cardSel    = (|fieldHit) && powerOkReg;
  assign depositNow = cardSel && dirNReg && !writeNReg && !sourceNReg;

  always_ff @(posedge clk) begin
    if (rst) depositPrev <= 1'b0;
    else     depositPrev <= depositNow;
  end

  assign strobe.wrStrobe = depositNow && !depositPrev;
  assign strobe.rdDrive  = cardSel && !dirNReg;

  // R5: one commit per rise of the deposit condition
  p_single_commit_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.wrStrobe |=> !strobe.wrStrobe);

  // R4: a commit traces back to a registered deposit on the bus
  p_commit_needs_deposit_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.wrStrobe |-> ($past(mdDirN) && !$past(writeN) && !$past(sourceN)));

  // R3: ROM overlay silences the card in the following cycle
  p_rom_silences_r3: assert property (@(posedge clk) disable iff (rst)
    !romSelN |=> (!strobe.rdDrive && !strobe.wrStrobe));

  // R7: missing power good silences the card in the following cycle
  p_power_inhibit_r7: assert property (@(posedge clk) disable iff (rst)
    !powerOk |=> (!strobe.rdDrive && !strobe.wrStrobe));
endmodule

// File: rtl/bank_memory_card_dp.sv
module bank_memory_card_dp
  import bank_memory_card_pkg::*;
#(
  parameter int FIELD_BITS = 3,
  parameter int IMPL_BITS  = 8,
  parameter int DATA_BITS  = 12,
  parameter int STORE_BITS = 16,
  localparam int IDX_BITS  = FIELD_BITS + IMPL_BITS,
  localparam int DEPTH     = 1 << IDX_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctlStrobe_t           strobe,
  input  logic [IDX_BITS-1:0]  idxReg,
  input  logic [DATA_BITS-1:0] dataReg,
  output logic                 dataOe,
  output logic [DATA_BITS-1:0] dataOut
);
  logic [STORE_BITS-1:0] storeArray [DEPTH];
  logic [STORE_BITS-1:0] wrWord, rdWord;

  // Spare storage bits are written as zero and never read out
  always_comb begin
    wrWord                = '0;
    wrWord[DATA_BITS-1:0] = dataReg;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrStrobe) storeArray[idxReg] <= wrWord;
  end

  assign rdWord  = storeArray[idxReg];
  assign dataOe  = strobe.rdDrive;
  assign dataOut = strobe.rdDrive ? rdWord[DATA_BITS-1:0] : '0;

  // R6: a steady read of an unchanged location returns a steady word
  p_read_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (dataOe && $past(dataOe) && $stable(idxReg) && !$past(strobe.wrStrobe)) |-> $stable(dataOut));

  // R8: a quiet bus carries zeros
  p_quiet_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe.rdDrive) |-> (dataOut == '0));
endmodule

// File: rtl/bank_memory_card.sv
module bank_memory_card
  import bank_memory_card_pkg::*;
#(
  parameter int FIELD_BITS = 3,
  parameter int ADDR_BITS  = 12,
  parameter int IMPL_BITS  = 8,
  parameter int DATA_BITS  = 12,
  parameter int STORE_BITS = 16,
  localparam int FIELDS    = 1 << FIELD_BITS,
  localparam int IDX_BITS  = FIELD_BITS + IMPL_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FIELD_BITS-1:0] fieldIn,
  input  logic [ADDR_BITS-1:0]  addrIn,
  input  logic [DATA_BITS-1:0]  mdIn,
  input  logic                  mdDirN,
  input  logic                  writeN,
  input  logic                  sourceN,
  input  logic                  romSelN,
  input  logic                  powerOk,
  input  logic [FIELDS-1:0]     fieldDisable,
  output logic                  dataOe,
  output logic [DATA_BITS-1:0]  dataOut
);
  ctlStrobe_t            strobe;
  logic [IDX_BITS-1:0]   idxReg;
  logic [DATA_BITS-1:0]  dataReg;

  bank_memory_card_ctrl #(
    .FIELD_BITS(FIELD_BITS), .ADDR_BITS(ADDR_BITS),
    .IMPL_BITS(IMPL_BITS), .DATA_BITS(DATA_BITS)
  ) i_ctrl (
    .clk(clk), .rst(rst), .fieldIn(fieldIn), .addrIn(addrIn), .mdIn(mdIn),
    .mdDirN(mdDirN), .writeN(writeN), .sourceN(sourceN), .romSelN(romSelN),
    .powerOk(powerOk), .fieldDisable(fieldDisable),
    .strobe(strobe), .idxReg(idxReg), .dataReg(dataReg)
  );

  bank_memory_card_dp #(
    .FIELD_BITS(FIELD_BITS), .IMPL_BITS(IMPL_BITS),
    .DATA_BITS(DATA_BITS), .STORE_BITS(STORE_BITS)
  ) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .idxReg(idxReg), .dataReg(dataReg),
    .dataOe(dataOe), .dataOut(dataOut)
  );
endmodule

// File: tb/test_bank_memory_card.sv
module test_bank_memory_card;
  localparam int IMPL = 4;
  localparam int DPF  = 1 << IMPL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  fieldIn = '0;
  logic [11:0] addrIn = '0;
  logic [11:0] mdIn = '0;
  logic        mdDirN = 1'b0, writeN = 1'b1, sourceN = 1'b1;
  logic        romSelN = 1'b1, powerOk = 1'b1;
  logic [7:0]  fieldDisable = '0;
  logic        dataOe;
  logic [11:0] dataOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R8";

  always #4 clk = ~clk;

  bank_memory_card #(.IMPL_BITS(IMPL)) i_bank_memory_card (
    .clk(clk), .rst(rst), .fieldIn(fieldIn), .addrIn(addrIn), .mdIn(mdIn),
    .mdDirN(mdDirN), .writeN(writeN), .sourceN(sourceN), .romSelN(romSelN),
    .powerOk(powerOk), .fieldDisable(fieldDisable),
    .dataOe(dataOe), .dataOut(dataOut)
  );

  // Behavioural reference: sampled bus view and a word table
  int   memM [8*DPF];
  bit   knownM [8*DPF];
  int   sField, sAddr, sData;
  bit   sDirN, sWrN, sSrcN, sRomN, sPok, prevDep;
  bit [7:0] sDis;

  function automatic bit mSel();
    return sRomN && sPok && !sDis[sField];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      sField = 0; sAddr = 0; sData = 0; sDis = '0;
      sDirN = 0; sWrN = 1; sSrcN = 1; sRomN = 0; sPok = 0; prevDep = 0;
      for (int i = 0; i < 8*DPF; i++) knownM[i] = 0;
    end else begin
      bit dep;
      dep = mSel() && sDirN && !sWrN && !sSrcN;
      if (dep && !prevDep) begin
        memM[sField*DPF + (sAddr % DPF)] = sData;
        knownM[sField*DPF + (sAddr % DPF)] = 1;
      end
      prevDep = dep;
      sField = int'(fieldIn); sAddr = int'(addrIn); sData = int'(mdIn);
      sDis = fieldDisable; sDirN = mdDirN; sWrN = writeN; sSrcN = sourceN;
      sRomN = romSelN; sPok = powerOk;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst) begin
      bit mOe;
      int idx;
      mOe = mSel() && !sDirN;
      idx = sField*DPF + (sAddr % DPF);
      check(curReq, "dataOe vs model", int'(dataOe), int'(mOe));
      if (!mOe) check("R8", "dataOut quiet", int'(dataOut), 0);
      else if (knownM[idx]) check(curReq, "dataOut vs model", int'(dataOut), memM[idx]);
    end
  end

  task automatic deposit(int f, int a, int d);
    @(negedge clk);
    fieldIn = 3'(f); addrIn = 12'(a); mdIn = 12'(d);
    mdDirN = 1; writeN = 0;
    @(negedge clk); sourceN = 0;
    repeat (3) @(negedge clk);
    sourceN = 1; writeN = 1;
    @(negedge clk); mdDirN = 0;
  endtask

  task automatic expectRead(string req, int f, int a, int exp);
    @(negedge clk);
    fieldIn = 3'(f); addrIn = 12'(a); mdDirN = 0;
    @(negedge clk); #1;
    check(req, "read enable", int'(dataOe), 1);
    check(req, "read word", int'(dataOut), exp);
  endtask

  task automatic expectSilent(string req, int f, int a);
    @(negedge clk);
    fieldIn = 3'(f); addrIn = 12'(a); mdDirN = 0;
    @(negedge clk); #1;
    check(req, "card silent", int'(dataOe), 0);
    check(req, "bus zero", int'(dataOut), 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        check("R8", "reset enable", int'(dataOe), 0);
        check("R8", "reset data", int'(dataOut), 0);
        rst = 0;

        curReq = "R1";
        deposit(0, 3, 'hABC);
        deposit(5, 3, 'h123);
        expectRead("R1", 0, 3, 'hABC);
        expectRead("R1", 5, 3, 'h123);

        curReq = "R6";
        expectRead("R6", 0, 3, 'hABC);
        repeat (3) @(negedge clk);
        expectRead("R6", 0, 3, 'hABC);

        curReq = "R9";
        expectRead("R9", 0, 3 + DPF, 'hABC);
        deposit(1, 2 + 4*DPF, 'h5A5);
        expectRead("R9", 1, 2, 'h5A5);

        curReq = "R2";
        fieldDisable = 8'b0010_0000;
        expectSilent("R2", 5, 3);
        deposit(5, 3, 'h777);
        expectRead("R2", 0, 3, 'hABC);
        fieldDisable = '0;
        expectRead("R2", 5, 3, 'h123);
        fieldDisable = 8'b0000_0001;
        expectSilent("R2", 0, 3);
        fieldDisable = '0;

        curReq = "R3";
        romSelN = 0;
        expectSilent("R3", 0, 3);
        deposit(0, 3, 'h555);
        romSelN = 1;
        expectRead("R3", 0, 3, 'hABC);

        curReq = "R7";
        powerOk = 0;
        expectSilent("R7", 0, 3);
        deposit(0, 3, 'h666);
        repeat (5) begin
          @(negedge clk); #1;
          check("R7", "held inhibit", int'(dataOe), 0);
        end
        powerOk = 1;
        expectRead("R7", 0, 3, 'hABC);

        curReq = "R4";
        @(negedge clk); mdIn = 12'h321; mdDirN = 1; writeN = 1; sourceN = 0;
        repeat (3) @(negedge clk);
        sourceN = 1; mdDirN = 0;
        @(negedge clk); writeN = 0; sourceN = 0;
        repeat (3) @(negedge clk);
        writeN = 1; sourceN = 1;
        expectRead("R4", 0, 3, 'hABC);

        curReq = "R5";
        deposit(0, 4, 'h0F0);
        @(negedge clk);
        fieldIn = 0; addrIn = 3; mdIn = 12'h111; mdDirN = 1; writeN = 0; sourceN = 0;
        repeat (3) @(negedge clk);
        addrIn = 4; mdIn = 12'h222;
        repeat (3) @(negedge clk);
        sourceN = 1; writeN = 1;
        @(negedge clk); mdDirN = 0;
        expectRead("R5", 0, 3, 'h111);
        expectRead("R5", 0, 4, 'h0F0);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        check("R8", "watchdog expired", 1, 0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule